// File: doc/BRIEF.md
# Redundant Sensor Input Validator

This block sits between two diverse sensor channels and the control logic that consumes their readings. One channel is the precise source; the other is simpler and more robust. On every sample strobe both readings are checked for plausibility (configured range, maximum step from the last accepted reading, and a stuck-input watch). The two are then compared, and one validated value leaves the block with a 2-bit quality code.

When the two channels roughly agree, the precise reading is forwarded. When they disagree beyond a tolerance, the robust reading wins and a mismatch flag is raised. If no usable reading exists, the block rides through the gap with a linear extrapolation of its recent output for a bounded number of sample periods. After that it declares the output failed and raises a fault report towards the reconfiguration controller. That controller can also force the output to come from one chosen channel.

Top module: `sensor_pair_validator`

## Requirements
- R1: A reading below `range_min` or above `range_max` is not accepted from that channel.
- R2: A reading whose absolute difference from that channel's last accepted reading exceeds `max_step` is not accepted. The first reading of a channel after reset skips this step test.
- R3: With automatic selection and both channels accepted, a difference of at most `pair_tol` forwards the precise reading with quality 2'b00. A larger difference forwards the robust reading with quality 2'b01 and sets `mismatch`. `mismatch` is updated on every sample and is 1 only when both channels are accepted and differ by more than `pair_tol`.
- R4: With automatic selection and only one channel accepted, that channel is forwarded (precise gives quality 2'b00, robust gives 2'b01).
- R5: With no usable reading, the output becomes the previous output plus the last good-sample delta, clamped to [`range_min`, `range_max`], with quality 2'b10. The delta is the difference between consecutive good outputs (zero for the first one) and is kept unchanged while extrapolating. This is allowed for at most HOLD_LIMIT consecutive samples.
- R6: Once HOLD_LIMIT substitutions are used up, each further unusable sample keeps the output value, gives quality 2'b11 and sets `fault_report`. The first usable sample clears `fault_report` and the substitution budget.
- R7: `sel_force` = 2'b01 uses only the precise channel (quality 2'b00), 2'b10 uses only the robust channel (quality 2'b01), and 2'b00 or 2'b11 select automatically. A forced channel that is not accepted leads to the R5/R6 path.
- R8: A channel whose raw reading equals its previous raw reading on STUCK_LEN consecutive samples is flagged on `stuck_prec`/`stuck_rob` and is not accepted until its reading changes.
- R9: `out_valid` pulses for one cycle in the cycle after each `sample_valid`. Outputs change only then.
- R10: After reset: `out_valid`=0, `out_data`=0, `out_quality`=2'b11, and `mismatch`, `fault_report` and both stuck flags are 0. No channel has a previous reading.

Ports table below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_valid | input | 1 | Both channel readings present this cycle |
| prec_data | input | DW | Precise channel reading |
| rob_data | input | DW | Robust channel reading |
| range_min | input | DW | Lowest plausible value |
| range_max | input | DW | Highest plausible value |
| max_step | input | DW | Largest accepted change between accepted readings |
| pair_tol | input | DW | Largest agreeing difference between channels |
| sel_force | input | 2 | Channel override from reconfiguration controller |
| out_valid | output | 1 | New validated value present |
| out_data | output | DW | Validated value |
| out_quality | output | 2 | 00 precise, 01 robust, 10 extrapolated, 11 failed |
| mismatch | output | 1 | Accepted channels disagree |
| fault_report | output | 1 | Substitution budget exhausted |
| stuck_prec | output | 1 | Precise channel frozen |
| stuck_rob | output | 1 | Robust channel frozen |

## Verification
The hardest state to reach is an extrapolation that saturates. It needs a non-zero good-sample delta, followed by a run of unusable samples close to a range limit. The stimulus ramps both channels steadily towards the upper limit and then makes both implausible, so the clamped substitutions and then the fault report follow. The stuck-channel path requires a reading frozen for several samples while the other channel keeps changing. Both paths are also mixed into a long pseudo-random phase with strobe gaps and override changes, compared against a behavioural model on every clock.

// File: rtl/svp_pkg.sv
package svp_pkg;
  typedef enum logic [1:0] {
    QUAL_PREC   = 2'b00,
    QUAL_ROB    = 2'b01,
    QUAL_EXTRAP = 2'b10,
    QUAL_FAIL   = 2'b11
  } quality_e;

  typedef enum logic [1:0] {
    SEL_AUTO     = 2'b00,
    SEL_PREC     = 2'b01,
    SEL_ROB      = 2'b10,
    SEL_AUTO_ALT = 2'b11
  } force_e;
endpackage

// File: rtl/svp_channel.sv
module svp_channel #(
  parameter int DW        = 12,
  parameter int STUCK_LEN = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_en,
  input  logic [DW-1:0] din,
  input  logic [DW-1:0] lo,
  input  logic [DW-1:0] hi,
  input  logic [DW-1:0] step_max,
  output logic          accept,
  output logic          stuck
);
  localparam int SW = $clog2(STUCK_LEN + 1);
  localparam logic [SW-1:0] SAME_MAX = SW'(STUCK_LEN);

  logic          has_prev_q, has_raw_q;
  logic [DW-1:0] last_acc_q, prev_raw_q;
  logic [SW-1:0] same_q, same_n;
  logic [DW-1:0] step_abs;
  logic          range_ok, step_ok;

  always_comb begin
    step_abs = (din > last_acc_q) ? (din - last_acc_q) : (last_acc_q - din);
    range_ok = (din >= lo) && (din <= hi);
    step_ok  = !has_prev_q || (step_abs <= step_max);
    if (has_raw_q && (din == prev_raw_q))
      same_n = (same_q < SAME_MAX) ? same_q + 1'b1 : same_q;
    else
      same_n = '0;
    accept = range_ok && step_ok && (same_n < SAME_MAX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      has_prev_q <= 1'b0;
      has_raw_q  <= 1'b0;
      last_acc_q <= '0;
      prev_raw_q <= '0;
      same_q     <= '0;
    end else if (smp_en) begin
      has_raw_q  <= 1'b1;
      prev_raw_q <= din;
      same_q     <= same_n;
      if (accept) begin
        has_prev_q <= 1'b1;
        last_acc_q <= din;
      end
    end
  end

  assign stuck = (same_q >= SAME_MAX);
endmodule

// File: rtl/svp_select.sv
module svp_select
  import svp_pkg::*;
#(
  parameter int DW = 12
) (
  input  logic          prec_ok,
  input  logic          rob_ok,
  input  logic [DW-1:0] prec_d,
  input  logic [DW-1:0] rob_d,
  input  logic [DW-1:0] tol,
  input  force_e        mode,
  output logic          pick_ok,
  output logic [DW-1:0] pick_d,
  output quality_e      pick_q,
  output logic          disagree
);
  logic [DW-1:0] gap;

  always_comb begin
    gap      = (prec_d > rob_d) ? (prec_d - rob_d) : (rob_d - prec_d);
    disagree = prec_ok && rob_ok && (gap > tol);
    pick_ok  = 1'b0;
    pick_d   = prec_d;
    pick_q   = QUAL_PREC;
    unique case (mode)
      SEL_PREC: pick_ok = prec_ok;
      SEL_ROB: begin
        pick_ok = rob_ok;
        pick_d  = rob_d;
        pick_q  = QUAL_ROB;
      end
      default: begin
        pick_ok = prec_ok || rob_ok;
        if (!prec_ok || disagree) begin
          pick_d = rob_d;
          pick_q = QUAL_ROB;
        end
      end
    endcase
  end
endmodule

// File: rtl/sensor_pair_validator.sv
module sensor_pair_validator
  import svp_pkg::*;
#(
  parameter int DW         = 12,
  parameter int HOLD_LIMIT = 4,
  parameter int STUCK_LEN  = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample_valid,
  input  logic [DW-1:0] prec_data,
  input  logic [DW-1:0] rob_data,
  input  logic [DW-1:0] range_min,
  input  logic [DW-1:0] range_max,
  input  logic [DW-1:0] max_step,
  input  logic [DW-1:0] pair_tol,
  input  logic [1:0]    sel_force,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic [1:0]    out_quality,
  output logic          mismatch,
  output logic          fault_report,
  output logic          stuck_prec,
  output logic          stuck_rob
);
  localparam int HW = $clog2(HOLD_LIMIT + 1);
  localparam logic [HW-1:0] HOLD_MAX = HW'(HOLD_LIMIT);

  logic [DW-1:0] chan_d     [2];
  logic          chan_ok    [2];
  logic          chan_stuck [2];

  assign chan_d[0] = prec_data;
  assign chan_d[1] = rob_data;

  for (genvar g = 0; g < 2; g++) begin : g_chan
    svp_channel #(.DW(DW), .STUCK_LEN(STUCK_LEN)) chan_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .smp_en   (sample_valid),
      .din      (chan_d[g]),
      .lo       (range_min),
      .hi       (range_max),
      .step_max (max_step),
      .accept   (chan_ok[g]),
      .stuck    (chan_stuck[g])
    );
  end

  logic          pick_ok, pair_mis;
  logic [DW-1:0] pick_d;
  quality_e      pick_q;

  svp_select #(.DW(DW)) sel_i (
    .prec_ok  (chan_ok[0]),
    .rob_ok   (chan_ok[1]),
    .prec_d   (chan_d[0]),
    .rob_d    (chan_d[1]),
    .tol      (pair_tol),
    .mode     (force_e'(sel_force)),
    .pick_ok  (pick_ok),
    .pick_d   (pick_d),
    .pick_q   (pick_q),
    .disagree (pair_mis)
  );

  logic                 valid_q, valid_n;
  logic [DW-1:0]        data_q, data_n;
  quality_e             qual_q, qual_n;
  logic                 mis_q, mis_n, fault_q, fault_n, hist_q, hist_n;
  logic signed [DW:0]   delta_q, delta_n;
  logic [HW-1:0]        hold_q, hold_n;
  logic signed [DW+1:0] sum_s, lo_s, hi_s;
  logic [DW-1:0]        extrap;

  always_comb begin
    sum_s = $signed({2'b00, data_q}) + $signed({delta_q[DW], delta_q});
    lo_s  = $signed({2'b00, range_min});
    hi_s  = $signed({2'b00, range_max});
    if (sum_s < lo_s)      extrap = range_min;
    else if (sum_s > hi_s) extrap = range_max;
    else                   extrap = sum_s[DW-1:0];
  end

  always_comb begin
    valid_n = sample_valid;
    data_n  = data_q;
    qual_n  = qual_q;
    mis_n   = mis_q;
    fault_n = fault_q;
    delta_n = delta_q;
    hist_n  = hist_q;
    hold_n  = hold_q;
    if (sample_valid) begin
      mis_n = pair_mis;
      if (pick_ok) begin
        data_n  = pick_d;
        qual_n  = pick_q;
        delta_n = hist_q ? ($signed({1'b0, pick_d}) - $signed({1'b0, data_q})) : '0;
        hist_n  = 1'b1;
        hold_n  = '0;
        fault_n = 1'b0;
      end else if (hold_q < HOLD_MAX) begin
        data_n = extrap;
        qual_n = QUAL_EXTRAP;
        hold_n = hold_q + 1'b1;
      end else begin
        qual_n  = QUAL_FAIL;
        fault_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      qual_q  <= QUAL_FAIL;
      mis_q   <= 1'b0;
      fault_q <= 1'b0;
      delta_q <= '0;
      hist_q  <= 1'b0;
      hold_q  <= '0;
    end else begin
      valid_q <= valid_n;
      if (sample_valid) begin
        data_q  <= data_n;
        qual_q  <= qual_n;
        mis_q   <= mis_n;
        fault_q <= fault_n;
        delta_q <= delta_n;
        hist_q  <= hist_n;
        hold_q  <= hold_n;
      end
    end
  end

  assign out_valid    = valid_q;
  assign out_data     = data_q;
  assign out_quality  = qual_q;
  assign mismatch     = mis_q;
  assign fault_report = fault_q;
  assign stuck_prec   = chan_stuck[0];
  assign stuck_rob    = chan_stuck[1];
endmodule

// File: rtl/svp_checker.sv
module svp_checker #(
  parameter int DW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sample_valid,
  input logic [DW-1:0] range_min,
  input logic [DW-1:0] range_max,
  input logic [1:0]    sel_force,
  input logic          out_valid,
  input logic [DW-1:0] out_data,
  input logic [1:0]    out_quality,
  input logic          mismatch,
  input logic          fault_report
);
  assert_valid_after_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(sample_valid));

  assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_data) && $stable(out_quality)));

  assert_extrap_clamped_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_quality == 2'b10) |->
      (out_data >= $past(range_min) && out_data <= $past(range_max)));

  assert_fail_reports_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_quality == 2'b11) |-> fault_report);

  assert_fault_clear_good_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_report) |-> (out_valid && out_quality[1] == 1'b0));

  assert_mismatch_robust_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && mismatch && ($past(sel_force) == 2'b00 || $past(sel_force) == 2'b11))
      |-> out_quality == 2'b01);

  assert_forced_robust_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(sel_force) == 2'b10) |-> out_quality != 2'b00);
endmodule

bind sensor_pair_validator svp_checker #(.DW(DW)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .sample_valid (sample_valid),
  .range_min    (range_min),
  .range_max    (range_max),
  .sel_force    (sel_force),
  .out_valid    (out_valid),
  .out_data     (out_data),
  .out_quality  (out_quality),
  .mismatch     (mismatch),
  .fault_report (fault_report)
);

// File: tb/sensor_pair_validator_tb_top.sv
module sensor_pair_validator_tb_top;
  localparam int DW = 12, HL = 4, SL = 6;
  localparam int LO = 100, HI = 3900, STEP = 200, TOL = 40;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, sample_valid, out_valid, mismatch, fault_report, stuck_prec, stuck_rob;
  logic [DW-1:0] prec_data, rob_data, range_min, range_max, max_step, pair_tol, out_data;
  logic [1:0]    sel_force, out_quality;

  sensor_pair_validator #(.DW(DW), .HOLD_LIMIT(HL), .STUCK_LEN(SL)) dut_i (
    .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .prec_data(prec_data),
    .rob_data(rob_data), .range_min(range_min), .range_max(range_max), .max_step(max_step),
    .pair_tol(pair_tol), .sel_force(sel_force), .out_valid(out_valid), .out_data(out_data),
    .out_quality(out_quality), .mismatch(mismatch), .fault_report(fault_report),
    .stuck_prec(stuck_prec), .stuck_rob(stuck_rob));

  int checks = 0, fails = 0;
  string cur_req = "R10";

  int pv_has[2], pv_acc[2], rw_has[2], rw_prev[2], rw_cnt[2];
  int m_delta, m_hist, m_hold;
  int e_valid, e_data, e_q, e_mis, e_fault, e_stk[2];

  task automatic chk(string req, string nm, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, nm, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R9", "out_valid", int'(out_valid), e_valid);
    chk(cur_req, "out_data", int'(out_data), e_data);
    chk(cur_req, "out_quality", int'(out_quality), e_q);
    chk(cur_req, "mismatch", int'(mismatch), e_mis);
    chk("R6", "fault_report", int'(fault_report), e_fault);
    chk("R8", "stuck_prec", int'(stuck_prec), e_stk[0]);
    chk("R8", "stuck_rob", int'(stuck_rob), e_stk[1]);
  endtask

  task automatic model_reset();
    for (int c = 0; c < 2; c++) begin
      pv_has[c] = 0; pv_acc[c] = 0; rw_has[c] = 0; rw_prev[c] = 0; rw_cnt[c] = 0; e_stk[c] = 0;
    end
    m_delta = 0; m_hist = 0; m_hold = 0;
    e_valid = 0; e_data = 0; e_q = 3; e_mis = 0; e_fault = 0;
  endtask

  function automatic int iabs(int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic m_chan(int c, int d, output bit ok);
    int sn;
    sn = (rw_has[c] != 0 && d == rw_prev[c]) ? ((rw_cnt[c] < SL) ? rw_cnt[c] + 1 : SL) : 0;
    ok = (d >= LO) && (d <= HI) && (pv_has[c] == 0 || iabs(d - pv_acc[c]) <= STEP) && (sn < SL);
    rw_has[c] = 1; rw_prev[c] = d; rw_cnt[c] = sn; e_stk[c] = (sn >= SL) ? 1 : 0;
    if (ok) begin pv_has[c] = 1; pv_acc[c] = d; end
  endtask

  task automatic apply(bit sv, int p, int r, int f);
    bit pok, rok, have;
    int val, q, s;
    @(negedge clk);
    compare_all();
    sample_valid = sv; prec_data = p[DW-1:0]; rob_data = r[DW-1:0]; sel_force = f[1:0];
    e_valid = sv ? 1 : 0;
    if (sv) begin
      m_chan(0, p, pok);
      m_chan(1, r, rok);
      e_mis = (pok && rok && iabs(p - r) > TOL) ? 1 : 0;
      have = 0; val = 0; q = 0;
      if (f == 1) begin have = pok; val = p; q = 0; end
      else if (f == 2) begin have = rok; val = r; q = 1; end
      else if (pok && !e_mis) begin have = 1; val = p; q = 0; end
      else if (rok) begin have = 1; val = r; q = 1; end
      if (have) begin
        m_delta = m_hist ? val - e_data : 0;
        m_hist = 1; m_hold = 0; e_fault = 0; e_data = val; e_q = q;
      end else if (m_hold < HL) begin
        s = e_data + m_delta;
        e_data = (s < LO) ? LO : (s > HI) ? HI : s;
        e_q = 2; m_hold++;
      end else begin
        e_q = 3; e_fault = 1;
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; sample_valid = 1'b0;
    model_reset();
    cur_req = "R10";
    @(negedge clk); compare_all();
    @(negedge clk); compare_all();
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog actual=timeout expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int b, p, r, f;
    rst_n = 1'b0; sample_valid = 1'b0; prec_data = '0; rob_data = '0; sel_force = 2'b00;
    range_min = DW'(LO); range_max = DW'(HI); max_step = DW'(STEP); pair_tol = DW'(TOL);
    model_reset();
    do_reset();

    cur_req = "R3"; // agreement, first sample skips step test (R2)
    for (int i = 0; i < 10; i++) begin apply(1, 1000 + i * 30, 1005 + i * 30, 0); apply(0, 0, 0, 0); end
    for (int i = 0; i < 4; i++) apply(1, 1300 + i * 10, 1200 + i * 10, 3);
    cur_req = "R1"; // precise out of range, robust only (R4)
    apply(1, 4000, 1240, 0); apply(1, 50, 1245, 0);
    cur_req = "R2";
    apply(1, 1800, 1250, 0); apply(1, 1340, 1255, 0);
    cur_req = "R5"; // both unusable: extrapolation then failure (R6)
    for (int i = 0; i < 7; i++) apply(1, 4000, 20, 0);
    cur_req = "R6";
    apply(1, 1260, 1258, 0); apply(1, 1270, 1268, 0);

    do_reset();
    cur_req = "R5"; // saturated extrapolation near upper limit
    for (int i = 0; i < 18; i++) apply(1, 1260 + i * 150, 1262 + i * 150, 0);
    for (int i = 0; i < 6; i++) apply(1, 4090, 4090, 0);

    do_reset();
    cur_req = "R7";
    for (int i = 0; i < 3; i++) apply(1, 2000 + i * 20, 1900 + i * 20, 1);
    for (int i = 0; i < 3; i++) apply(1, 2060 + i * 20, 2062 + i * 20, 2);
    apply(1, 4000, 2120, 1); apply(1, 2120, 2121, 0);
    cur_req = "R8"; // robust frozen, precise alive
    for (int i = 0; i < 9; i++) apply(1, 2120 + (i % 2) * 3, 2121, 0);
    apply(1, 2125, 2121, 2); apply(1, 2126, 2121, 2);
    apply(1, 2127, 2130, 0); apply(1, 2128, 2131, 0);

    do_reset();
    cur_req = "R4"; // mixed pseudo-random phase
    b = 2000; f = 0;
    for (int i = 0; i < 600; i++) begin
      b = b + int'($urandom_range(120)) - 60;
      if (b < 300) b = 300;
      if (b > 3700) b = 3700;
      p = b + int'($urandom_range(20)) - 10;
      r = b + int'($urandom_range(40)) - 20;
      if ($urandom_range(99) < 6) p = 4050;
      if ($urandom_range(99) < 6) r = b + 300;
      if ($urandom_range(99) < 4) p = 20;
      if ($urandom_range(99) < 8) r = rw_prev[1];
      if ($urandom_range(99) < 4) f = int'($urandom_range(3));
      apply($urandom_range(99) < 70, p, r, f);
    end
    apply(0, 0, 0, 0);
    @(negedge clk); compare_all();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule